// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block models the device-side timing of SDRAM read bursts. Each READ command brings a bank number, a 9-bit starting column, an auto-precharge flag and a burst-order select. After a fixed CAS latency the block puts out one column address per cycle, with the bank it belongs to and a valid strobe. It does this for a burst of programmed length, in sequential or interleaved order.

The command fields travel through a delay pipeline whose depth is set by the CAS latency. A new READ can therefore be accepted while an earlier burst is still being delivered. READs issued every BL cycles to alternating banks give an unbroken stream of valid words. A READ that arrives sooner than that cuts the running burst short: its own first word replaces the old sequence exactly CL cycles after the new command.

One small timer per bank reports when internal precharge begins for a READ with auto-precharge. A testbench or bus model compares the column stream and these pulses against its own expectations. The block holds no storage array and does not check command spacing.

Top module: `sdram_rd_burst_seq`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, dq_valid is 0 and pre_start is all zeros.
- R2: A READ is sampled on the rising edge where rd_cmd is 1. Its first word is visible at the CAS_LAT-th rising edge after that one (edge k+CAS_LAT). At that point dq_valid is 1, dq_bank equals rd_bank and dq_col equals rd_col, as given with the command.
- R3: When no further READ follows, a burst holds dq_valid at 1 for exactly BURST_LEN consecutive cycles, and dq_valid then returns to 0.
- R4: With rd_ileave = 0 (sequential), word i has column bits above the low log2(BURST_LEN) bits equal to the start column. Its low bits equal (start low bits + i) modulo BURST_LEN.
- R5: With rd_ileave = 1 (interleaved), word i has column bits above the low log2(BURST_LEN) bits equal to the start column. Its low bits equal the start low bits XOR i.
- R6: READs issued exactly BURST_LEN cycles apart to alternating banks give dq_valid high on every cycle from the first word of the first burst to the last word of the last burst. Each word carries its own burst's bank and column.
- R7: A READ sampled while a burst is still being output ends that burst. The old burst's words continue until edge k+CAS_LAT of the new READ. From that edge on, the new burst's words appear in full.
- R8: For a READ with rd_autopre = 1 to bank b, pre_start bit b is 1 at rising edge k+BURST_LEN only, and 0 on the edges just before and after it.
- R9: pre_start never goes high unless a READ with rd_autopre = 1 was sampled BURST_LEN cycles earlier. A READ with rd_autopre = 0 leaves pre_start at zero.
- R10: dq_bank stays constant throughout the words of one burst. In both orders, the column bits above the low log2(BURST_LEN) bits never change within a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_cmd | input | 1 | READ command strobe, one cycle per command |
| rd_bank | input | 2 | Bank addressed by the READ |
| rd_col | input | 9 | Starting column of the burst |
| rd_autopre | input | 1 | 1 requests auto-precharge after the burst |
| rd_ileave | input | 1 | Burst order: 0 sequential, 1 interleaved |
| dq_valid | output | 1 | A burst word is present this cycle |
| dq_bank | output | 2 | Bank of the present word |
| dq_col | output | 9 | Column of the present word |
| pre_start | output | 4 | One bit per bank; pulses when internal precharge begins |

## Verification
The checker watches every cycle for the following:
- the CAS-latency relation between a READ and its first word, including bank and column;
- valid strobes that rise without a matching command;
- the bank and upper column bits staying fixed inside a burst;
- precharge pulses that are not one-hot, or that lack an auto-precharge READ BURST_LEN cycles earlier.

Only the bench scenarios can show the exact column order of each burst type with wrap-around, the exact burst length, gap-free output across alternating banks, and the point where a truncated burst hands over to its successor.

// File: rtl/sdram_rd_pkg.sv
// Shared constants, the launch record and the burst column function
// for the SDRAM read burst sequencer.
// Assumes: burst lengths of at most 8, so a 4-bit word index suffices.
package sdram_rd_pkg;

    localparam int COL_W  = 9;
    localparam int BANK_W = 2;
    localparam int NBANK  = 1 << BANK_W;
    localparam int IDX_W  = 4;

    typedef struct packed {
        logic              ileave;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } rd_launch_t;

    // Column of word idx in a burst that starts at start, group of 2**lg words.
    function automatic logic [COL_W-1:0] burst_col(
        input logic [COL_W-1:0] start,
        input logic [IDX_W-1:0] idx,
        input logic             ileave,
        input int unsigned      lg
    );
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] ext;
        mask = COL_W'((1 << lg) - 1);
        ext  = {{(COL_W-IDX_W){1'b0}}, idx};
        if (ileave)
            return start ^ (ext & mask);
        return (start & ~mask) | ((start + ext) & mask);
    endfunction

endpackage

// File: rtl/sdram_rd_cl_pipe.sv
// CAS-latency delay line: carries a strobe and its payload DEPTH cycles.
// Assumes: DEPTH >= 1; the payload is only meaningful where the strobe is set.
module sdram_rd_cl_pipe #(
    parameter int DEPTH = 2,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);

    logic [DEPTH-1:0] vld_q;
    logic [W-1:0]     data_q [DEPTH];

    // Shift the strobe, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= in_vld;
            for (int s = 1; s < DEPTH; s++)
                vld_q[s] <= vld_q[s-1];
        end
    end

    // Shift the payload alongside the strobe.
    always_ff @(posedge clk) begin
        data_q[0] <= in_data;
        for (int s = 1; s < DEPTH; s++)
            data_q[s] <= data_q[s-1];
    end

    assign out_vld  = vld_q[DEPTH-1];
    assign out_data = data_q[DEPTH-1];

endmodule

// File: rtl/sdram_rd_burst_gen.sv
// Burst generator: on a launch, outputs the start word at once and then the
// remaining BURST_LEN-1 words one per cycle; a new launch restarts it.
// Assumes: BURST_LEN is 1, 2, 4 or 8.
module sdram_rd_burst_gen
    import sdram_rd_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_vld,
    input  rd_launch_t        launch,
    output logic              dq_valid,
    output logic [BANK_W-1:0] dq_bank,
    output logic [COL_W-1:0]  dq_col
);

    localparam int unsigned LG = $clog2(BURST_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

    logic             act_q;
    logic [IDX_W-1:0] idx_q;
    logic [COL_W-1:0] start_q;
    logic             ileave_q;

    // Word sequencing: a launch has priority over the burst already running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            idx_q    <= '0;
            start_q  <= '0;
            ileave_q <= 1'b0;
            dq_valid <= 1'b0;
            dq_bank  <= '0;
            dq_col   <= '0;
        end else if (launch_vld) begin
            act_q    <= (BURST_LEN > 1);
            idx_q    <= IDX_W'(1);
            start_q  <= launch.col;
            ileave_q <= launch.ileave;
            dq_valid <= 1'b1;
            dq_bank  <= launch.bank;
            dq_col   <= launch.col;
        end else if (act_q) begin
            dq_valid <= 1'b1;
            dq_col   <= burst_col(start_q, idx_q, ileave_q, LG);
            idx_q    <= idx_q + IDX_W'(1);
            act_q    <= (idx_q != LAST_IDX);
        end else begin
            dq_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sdram_rd_apre_timer.sv
// Auto-precharge timer for one bank: fire is high exactly BURST_LEN cycles
// after the arming edge, for one cycle.
// Assumes: re-arming restarts the count.
module sdram_rd_apre_timer #(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic fire
);

    logic [3:0] cnt_q;

    // Load on arm, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (arm)
            cnt_q <= 4'(BURST_LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 4'd1;
    end

    assign fire = (cnt_q == 4'd1);

endmodule

// File: rtl/sdram_rd_burst_seq.sv
// SDRAM read burst sequencer top: delays each READ by the CAS latency,
// generates its burst of columns, and times auto-precharge per bank.
// Assumes: CAS_LAT is 2 or 3, BURST_LEN is 1, 2, 4 or 8, at most one READ per cycle.
module sdram_rd_burst_seq
    import sdram_rd_pkg::*;
#(
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              rd_autopre,
    input  logic              rd_ileave,
    output logic              dq_valid,
    output logic [BANK_W-1:0] dq_bank,
    output logic [COL_W-1:0]  dq_col,
    output logic [NBANK-1:0]  pre_start
);

    localparam int PIPE_DEPTH = CAS_LAT - 1;
    localparam int REQ_W      = $bits(rd_launch_t);

    rd_launch_t       req_in;
    rd_launch_t       req_out;
    logic [REQ_W-1:0] req_out_vec;
    logic             launch_vld;

    // Pack the command fields for the delay line.
    always_comb begin
        req_in.ileave = rd_ileave;
        req_in.bank   = rd_bank;
        req_in.col    = rd_col;
    end

    sdram_rd_cl_pipe #(
        .DEPTH (PIPE_DEPTH),
        .W     (REQ_W)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (rd_cmd),
        .in_data  (req_in),
        .out_vld  (launch_vld),
        .out_data (req_out_vec)
    );

    assign req_out = rd_launch_t'(req_out_vec);

    sdram_rd_burst_gen #(
        .BURST_LEN (BURST_LEN)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_vld (launch_vld),
        .launch     (req_out),
        .dq_valid   (dq_valid),
        .dq_bank    (dq_bank),
        .dq_col     (dq_col)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic arm;
        assign arm = rd_cmd && rd_autopre && (rd_bank == BANK_W'(b));

        sdram_rd_apre_timer #(
            .BURST_LEN (BURST_LEN)
        ) u_apre (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (arm),
            .fire  (pre_start[b])
        );
    end

endmodule

// File: rtl/sdram_rd_burst_seq_chk.sv
// Protocol checker for the read burst sequencer, bound to the top module.
// Assumes: CAS_LAT and BURST_LEN are small (at most 3 and 8).
module sdram_rd_burst_seq_chk
    import sdram_rd_pkg::*;
#(
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_cmd,
    input logic [BANK_W-1:0] rd_bank,
    input logic [COL_W-1:0]  rd_col,
    input logic              rd_autopre,
    input logic              dq_valid,
    input logic [BANK_W-1:0] dq_bank,
    input logic [COL_W-1:0]  dq_col,
    input logic [NBANK-1:0]  pre_start
);

    localparam logic [COL_W-1:0] HI_MASK = ~COL_W'((1 << $clog2(BURST_LEN)) - 1);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!dq_valid && pre_start == '0));

    p_first_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_cmd, CAS_LAT) |->
            (dq_valid && dq_col == $past(rd_col, CAS_LAT) && dq_bank == $past(rd_bank, CAS_LAT)));

    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && !$past(dq_valid)) |-> $past(rd_cmd, CAS_LAT));

    p_same_group_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && $past(dq_valid) && !$past(rd_cmd, CAS_LAT)) |->
            ((dq_col & HI_MASK) == ($past(dq_col) & HI_MASK) && dq_bank == $past(dq_bank)));

    p_apre_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_cmd && rd_autopre, BURST_LEN) |-> (pre_start != '0));

    p_apre_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pre_start));

    p_apre_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_start != '0) |-> $past(rd_cmd && rd_autopre, BURST_LEN));

endmodule

bind sdram_rd_burst_seq sdram_rd_burst_seq_chk #(
    .CAS_LAT   (CAS_LAT),
    .BURST_LEN (BURST_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_cmd     (rd_cmd),
    .rd_bank    (rd_bank),
    .rd_col     (rd_col),
    .rd_autopre (rd_autopre),
    .dq_valid   (dq_valid),
    .dq_bank    (dq_bank),
    .dq_col     (dq_col),
    .pre_start  (pre_start)
);

// File: tb/sdram_rd_burst_seq_bench.sv
// Directed bench for the read burst sequencer; one task per scenario.
module sdram_rd_burst_seq_bench;

    localparam int PERIOD = 10;
    localparam int CL     = 3;
    localparam int BL     = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rd_cmd;
    logic [1:0] rd_bank;
    logic [8:0] rd_col;
    logic       rd_autopre;
    logic       rd_ileave;
    logic       dq_valid;
    logic [1:0] dq_bank;
    logic [8:0] dq_col;
    logic [3:0] pre_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sdram_rd_burst_seq #(
        .CAS_LAT   (CL),
        .BURST_LEN (BL)
    ) u_sdram_rd_burst_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cmd     (rd_cmd),
        .rd_bank    (rd_bank),
        .rd_col     (rd_col),
        .rd_autopre (rd_autopre),
        .rd_ileave  (rd_ileave),
        .dq_valid   (dq_valid),
        .dq_bank    (dq_bank),
        .dq_col     (dq_col),
        .pre_start  (pre_start)
    );

    // Expected column of word i, by modular arithmetic on the burst group.
    function automatic logic [8:0] exp_col(input logic [8:0] s, input int i, input bit il);
        int base = int'(s) - (int'(s) % BL);
        int off  = int'(s) % BL;
        if (il) return 9'(base + (off ^ i));
        return 9'(base + ((off + i) % BL));
    endfunction

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input logic [1:0] b, input logic [8:0] c);
        chk(dq_valid === 1'b1 && dq_bank === b && dq_col === c, req,
            $sformatf("v=%b bank=%0d col=%h", dq_valid, dq_bank, dq_col),
            $sformatf("v=1 bank=%0d col=%h", b, c));
    endtask

    task automatic chk_idle(input string req);
        chk(dq_valid === 1'b0, req, $sformatf("v=%b", dq_valid), "v=0");
    endtask

    // Drive one READ for one clock edge; returns at the negedge after it.
    task automatic issue(input logic [1:0] b, input logic [8:0] c, input bit ap, input bit il);
        rd_cmd = 1'b1; rd_bank = b; rd_col = c; rd_autopre = ap; rd_ileave = il;
        @(negedge clk);
        rd_cmd = 1'b0; rd_autopre = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rd_cmd = 1'b0; rd_bank = '0; rd_col = '0; rd_autopre = 1'b0; rd_ileave = 1'b0;
        repeat (3) @(negedge clk);
        chk(dq_valid === 1'b0 && pre_start === 4'b0000, "R1",
            $sformatf("v=%b pre=%b", dq_valid, pre_start), "v=0 pre=0000");
        rst_n = 1'b1;
        @(negedge clk);
        chk(dq_valid === 1'b0 && pre_start === 4'b0000, "R1",
            $sformatf("v=%b pre=%b", dq_valid, pre_start), "v=0 pre=0000");
    endtask

    task automatic t_burst(input logic [1:0] b, input logic [8:0] c, input bit il, input string req);
        issue(b, c, 1'b0, il);
        repeat (CL - 2) @(negedge clk);
        chk_idle("R2 before latency");
        @(negedge clk);
        for (int i = 0; i < BL; i++) begin
            chk_word((i == 0) ? "R2" : req, b, exp_col(c, i, il));
            @(negedge clk);
        end
        chk_idle("R3");
        repeat (2) @(negedge clk);
    endtask

    task automatic t_alternate();
        fork
            begin
                issue(2'd0, 9'h010, 1'b0, 1'b0);
                repeat (BL - 1) @(negedge clk);
                issue(2'd1, 9'h0F3, 1'b0, 1'b0);
                repeat (BL - 1) @(negedge clk);
                issue(2'd0, 9'h1C5, 1'b0, 1'b1);
            end
            begin
                repeat (CL) @(negedge clk);
                for (int i = 0; i < BL; i++) begin chk_word("R6", 2'd0, exp_col(9'h010, i, 1'b0)); @(negedge clk); end
                for (int i = 0; i < BL; i++) begin chk_word("R6", 2'd1, exp_col(9'h0F3, i, 1'b0)); @(negedge clk); end
                for (int i = 0; i < BL; i++) begin chk_word("R6", 2'd0, exp_col(9'h1C5, i, 1'b1)); @(negedge clk); end
                chk_idle("R6 end");
            end
        join
        repeat (2) @(negedge clk);
    endtask

    task automatic t_truncate();
        fork
            begin
                issue(2'd2, 9'h044, 1'b0, 1'b0);
                @(negedge clk);
                issue(2'd3, 9'h12A, 1'b0, 1'b0);
            end
            begin
                repeat (CL) @(negedge clk);
                chk_word("R7 old word0", 2'd2, exp_col(9'h044, 0, 1'b0));
                @(negedge clk);
                chk_word("R7 old word1", 2'd2, exp_col(9'h044, 1, 1'b0));
                @(negedge clk);
                for (int i = 0; i < BL; i++) begin chk_word("R7", 2'd3, exp_col(9'h12A, i, 1'b0)); @(negedge clk); end
                chk_idle("R7 end");
            end
        join
        repeat (2) @(negedge clk);
    endtask

    task automatic t_autopre();
        issue(2'd2, 9'h033, 1'b1, 1'b0);
        repeat (BL - 2) @(negedge clk);
        chk(pre_start === 4'b0000, "R8 early", $sformatf("%b", pre_start), "0000");
        @(negedge clk);
        chk(pre_start === 4'b0100, "R8", $sformatf("%b", pre_start), "0100");
        @(negedge clk);
        chk(pre_start === 4'b0000, "R8 late", $sformatf("%b", pre_start), "0000");
        repeat (4) @(negedge clk);
    endtask

    task automatic t_no_autopre();
        bit seen = 1'b0;
        issue(2'd1, 9'h077, 1'b0, 1'b0);
        for (int i = 0; i < BL + 3; i++) begin
            if (pre_start !== 4'b0000) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R9", $sformatf("pulse=%b", seen), "pulse=0");
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_burst(2'd1, 9'h0A6, 1'b0, "R4");
        t_burst(2'd3, 9'h13D, 1'b1, "R5");
        t_burst(2'd0, 9'h1FF, 1'b0, "R10");
        t_alternate();
        t_truncate();
        t_autopre();
        t_no_autopre();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule